// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog for a chip's always-on domain. A down-counter moves one step on every cycle where the tick-enable input is high, as long as the run bit in the control register is set. When the count runs out for the first time, the block raises a raw timeout flag, drives the interrupt (if enabled) and starts counting again from the programmed load value. If software has not cleared the flag by the time the count runs out a second time, and the reset path is enabled, the block drives its reset request output.

Software talks to the block over a flat 32-bit register port: address, write strobe, write data, and combinational read data. A write-guard register holds every other register read-only until the right 32-bit key is written to it. Software servicing the watchdog writes the clear register. That write drops the flag and any pending reset request, and it restarts the count.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the guard is locked, the load value and the count are both 0xFFFFFFFF, the control register reads 0, and the interrupt and reset outputs are low.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the other registers. Writing any other value there locks them. Reading 0xC00 returns 1 when locked and 0 when unlocked.
- R3: While the guard is locked, writes to any register other than 0xC00 have no effect.
- R4: A write to offset 0x000 stores the load value, with 0 replaced by 1, and reloads the count with it at once. Offset 0x000 reads the load value. Offset 0x004 reads the live count, which never exceeds the load value.
- R5: The count falls by one on each cycle with tick_en high while control bit 0 (run) is set. Otherwise it holds.
- R6: A tick taken at count 0 reloads the count from the load value and sets the raw flag. One stage therefore lasts load+1 ticks.
- R7: Offset 0x008 reads control bits [1:0]. Bit 0 of offset 0x010 is the raw flag. Bit 0 of offset 0x014, and the irq output, equal the raw flag ANDed with control bit 0.
- R8: A second expiry while the raw flag is still set raises the reset output, but only when control bit 1 is set. With bit 1 clear, the reset output stays low. From a clear, reset follows after 2*(load+1) ticks.
- R9: Once high, the reset output stays high until an accepted write to the clear register or a system reset.
- R10: An accepted write of any value to offset 0x00C clears the raw flag and the reset output and reloads the count from the load value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable pulse |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Masked timeout interrupt |
| wdt_rst_o | output | 1 | Reset request |

## Verification
The checker watches five properties on every cycle:
- a locked write never moves the load value;
- the count never exceeds the load value;
- the interrupt is never high without the run bit;
- a reset request only rises after a pending flag with the reset path enabled;
- once raised, the request holds until an accepted clear.

Only the bench scenarios can show the following:
- the exact stage length of load+1 ticks;
- the zero-to-one load substitution;
- the key and lock readback values;
- that a second expiry with the reset path disabled leaves the output low;
- that a clear write is ignored while locked.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DW = 32;
    localparam int AW = 12;

    localparam int OFS_LOAD  = 'h000;
    localparam int OFS_VALUE = 'h004;
    localparam int OFS_CTRL  = 'h008;
    localparam int OFS_CLR   = 'h00C;
    localparam int OFS_RAW   = 'h010;
    localparam int OFS_MSK   = 'h014;
    localparam int OFS_LOCK  = 'hC00;

    localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

    typedef struct packed {
        logic rst_en;
        logic run_en;
    } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DW = wdog_pkg::DW,
    parameter int AW = wdog_pkg::AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] cnt_i,
    input  logic          raw_i,
    output logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] load_o,
    output logic [DW-1:0] load_nxt_o,
    output ctrl_t         ctrl_o,
    output logic          locked_o,
    output logic          load_wr_o,
    output logic          clr_wr_o
);
    typedef struct packed {
        logic          locked;
        logic [DW-1:0] load;
        ctrl_t         ctrl;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ok;
    logic  ctrl_wr;

    always_comb begin
        r_d       = r_q;
        wr_ok     = bus_we && !r_q.locked;
        load_wr_o = wr_ok && (bus_addr == AW'(OFS_LOAD));
        clr_wr_o  = wr_ok && (bus_addr == AW'(OFS_CLR));
        ctrl_wr   = wr_ok && (bus_addr == AW'(OFS_CTRL));

        if (bus_we && (bus_addr == AW'(OFS_LOCK)))
            r_d.locked = (bus_wdata != DW'(UNLOCK_KEY));
        if (load_wr_o)
            r_d.load = (bus_wdata == '0) ? DW'(1) : bus_wdata;
        if (ctrl_wr)
            r_d.ctrl = ctrl_t'(bus_wdata[1:0]);

        bus_rdata = '0;
        case (bus_addr)
            AW'(OFS_LOAD):  bus_rdata = r_q.load;
            AW'(OFS_VALUE): bus_rdata = cnt_i;
            AW'(OFS_CTRL):  bus_rdata = DW'(r_q.ctrl);
            AW'(OFS_RAW):   bus_rdata = DW'(raw_i);
            AW'(OFS_MSK):   bus_rdata = DW'(raw_i & r_q.ctrl.run_en);
            AW'(OFS_LOCK):  bus_rdata = DW'(r_q.locked);
            default:        bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.locked <= 1'b1;
            r_q.load   <= '1;
            r_q.ctrl   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign load_o     = r_q.load;
    assign load_nxt_o = r_d.load;
    assign ctrl_o     = r_q.ctrl;
    assign locked_o   = r_q.locked;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int DW = wdog_pkg::DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  ctrl_t         ctrl_i,
    input  logic [DW-1:0] load_nxt_i,
    input  logic          load_wr_i,
    input  logic          clr_wr_i,
    output logic [DW-1:0] cnt_o,
    output logic          raw_o,
    output logic          rst_o
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          raw;
        logic          rst;
    } core_t;

    core_t c_d, c_q;
    logic  step;
    logic  expire;

    always_comb begin
        c_d    = c_q;
        step   = tick_i && ctrl_i.run_en;
        expire = step && (c_q.cnt == '0);

        // bus reloads win over a tick in the same cycle
        if (load_wr_i || clr_wr_i)
            c_d.cnt = load_nxt_i;
        else if (step)
            c_d.cnt = expire ? load_nxt_i : c_q.cnt - DW'(1);

        if (clr_wr_i) begin
            c_d.raw = 1'b0;
            c_d.rst = 1'b0;
        end else if (expire) begin
            c_d.raw = 1'b1;
            if (c_q.raw && ctrl_i.rst_en)
                c_d.rst = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.cnt <= '1;
            c_q.raw <= 1'b0;
            c_q.rst <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_o = c_q.cnt;
    assign raw_o = c_q.raw;
    assign rst_o = c_q.rst;
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
    import wdog_pkg::*;
#(
    parameter int DW = wdog_pkg::DW,
    parameter int AW = wdog_pkg::AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o,
    output logic          wdt_rst_o
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] load_q;
    logic [DW-1:0] load_nxt;
    logic          raw;
    logic          locked;
    logic          load_wr;
    logic          clr_wr;
    ctrl_t         ctrl;

    wdog_regs #(.DW(DW), .AW(AW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .cnt_i     (cnt),
        .raw_i     (raw),
        .bus_rdata (bus_rdata),
        .load_o    (load_q),
        .load_nxt_o(load_nxt),
        .ctrl_o    (ctrl),
        .locked_o  (locked),
        .load_wr_o (load_wr),
        .clr_wr_o  (clr_wr)
    );

    wdog_core #(.DW(DW)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_en),
        .ctrl_i    (ctrl),
        .load_nxt_i(load_nxt),
        .load_wr_i (load_wr),
        .clr_wr_i  (clr_wr),
        .cnt_o     (cnt),
        .raw_o     (raw),
        .rst_o     (wdt_rst_o)
    );

    assign irq_o = raw & ctrl.run_en;
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk
    import wdog_pkg::*;
#(
    parameter int DW = wdog_pkg::DW,
    parameter int AW = wdog_pkg::AW
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic          irq_o,
    input logic          wdt_rst_o,
    input logic          locked,
    input logic          clr_wr,
    input logic          raw,
    input logic [DW-1:0] load_q,
    input logic [DW-1:0] cnt,
    input ctrl_t         ctrl
);
    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && locked && bus_addr == AW'(OFS_LOAD)) |=> $stable(load_q));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= load_q);

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctrl.run_en);

    // R8
    rst_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_o) |-> ($past(raw) && $past(ctrl.rst_en)));

    // R9
    rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst_o && !clr_wr) |=> wdt_rst_o);
endmodule

bind wdog_twostage wdog_twostage_chk #(.DW(DW), .AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .irq_o    (irq_o),
    .wdt_rst_o(wdt_rst_o),
    .locked   (locked),
    .clr_wr   (clr_wr),
    .raw      (raw),
    .load_q   (load_q),
    .cnt      (cnt),
    .ctrl     (ctrl)
);

// File: tb/wdog_twostage_tb_top.sv
module wdog_twostage_tb_top;
    localparam int KIND_RD  = 0;
    localparam int KIND_IRQ = 1;
    localparam int KIND_RST = 2;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        wdt_rst_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    wdog_twostage dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o),
        .wdt_rst_o(wdt_rst_o)
    );

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    KIND_IRQ: act = {31'b0, irq_o};
                    KIND_RST: act = {31'b0, wdt_rst_o};
                    default:  act = bus_rdata;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [11:0] addr,
                        input logic [31:0] exp, input string req);
        item_t it;
        bus_addr = addr;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [11:0] addr, input logic [31:0] exp, input string req);
        push(KIND_RD, addr, exp, req);
    endtask

    task automatic wr(input logic [11:0] addr, input logic [31:0] data);
        bus_addr  = addr;
        bus_wdata = data;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 reset state
        rd(12'hC00, 32'h1, "R1 lock");
        rd(12'h000, 32'hFFFFFFFF, "R1 load");
        rd(12'h004, 32'hFFFFFFFF, "R1 count");
        rd(12'h008, 32'h0, "R1 control");
        push(KIND_IRQ, 12'h000, 32'h0, "R1 irq");
        push(KIND_RST, 12'h000, 32'h0, "R1 rst");
        // R3 locked write ignored
        wr(12'h000, 32'h5);
        rd(12'h000, 32'hFFFFFFFF, "R3 locked load");
        // R2 unlock
        wr(12'hC00, 32'h1ACCE551);
        rd(12'hC00, 32'h0, "R2 unlocked");
        // R4 zero becomes one, load reloads count
        wr(12'h000, 32'h0);
        rd(12'h000, 32'h1, "R4 zero load");
        wr(12'h000, 32'h3);
        rd(12'h004, 32'h3, "R4 count reload");
        // R5 no counting while run clear
        ticks(10);
        rd(12'h004, 32'h3, "R5 run off");
        wr(12'h008, 32'h1);
        ticks(2);
        rd(12'h004, 32'h1, "R5 count down");
        repeat (3) @(posedge clk);
        #1;
        rd(12'h004, 32'h1, "R5 tick low holds");
        // R6 expiry after load+1 ticks
        ticks(2);
        rd(12'h004, 32'h3, "R6 reload at expiry");
        rd(12'h010, 32'h1, "R6 raw set");
        rd(12'h014, 32'h1, "R7 masked set");
        push(KIND_IRQ, 12'h000, 32'h1, "R7 irq");
        // R8 second expiry with reset path off
        ticks(4);
        push(KIND_RST, 12'h000, 32'h0, "R8 rst disabled");
        // R7 masking
        wr(12'h008, 32'h0);
        push(KIND_IRQ, 12'h000, 32'h0, "R7 irq masked");
        rd(12'h010, 32'h1, "R7 raw kept");
        rd(12'h014, 32'h0, "R7 masked clear");
        // R10 clear
        wr(12'h00C, 32'hDEAD);
        rd(12'h010, 32'h0, "R10 raw cleared");
        rd(12'h004, 32'h3, "R10 reload");
        // R8 two-stage reset
        wr(12'h008, 32'h3);
        rd(12'h008, 32'h3, "R7 control read");
        ticks(4);
        push(KIND_RST, 12'h000, 32'h0, "R8 first stage");
        rd(12'h010, 32'h1, "R8 flag after stage one");
        ticks(3);
        push(KIND_RST, 12'h000, 32'h0, "R8 before second expiry");
        ticks(1);
        push(KIND_RST, 12'h000, 32'h1, "R8 reset asserted");
        // R9 sticky, locked clear ignored
        wr(12'hC00, 32'h1);
        rd(12'hC00, 32'h1, "R2 relocked");
        wr(12'h00C, 32'h0);
        push(KIND_RST, 12'h000, 32'h1, "R9 locked clear ignored");
        wr(12'h008, 32'h0);
        rd(12'h008, 32'h3, "R3 locked control");
        repeat (5) @(posedge clk);
        #1;
        push(KIND_RST, 12'h000, 32'h1, "R9 held");
        // R10 clear drops reset
        wr(12'hC00, 32'h1ACCE551);
        wr(12'h00C, 32'h0);
        push(KIND_RST, 12'h000, 32'h0, "R10 reset cleared");
        rd(12'h010, 32'h0, "R10 raw after clear");
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule